// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block drives the coil switch of a low-frequency proximity transponder that answers with frequency-shift keyed load modulation. The external reader field is brought in as a square wave. The block synchronises it to the system clock and emits one modulation level for each rising field edge. It does this from a sequencer that works on the fly, so no pre-computed sample memory is needed. Two basic units are used. The short unit lasts 8 field cycles and the long unit lasts 10. Units are grouped into bit cells that use transitions in the style of Manchester coding. A deliberately invalid start marker opens each frame, and a short separator unit is placed in front of every nibble of the 44-bit identifier. The frame repeats until a stop request arrives.

A start pulse latches the identifier, which is split into an upper word and a lower word, and begins transmission. An upper word wider than 12 significant bits is refused, and the block stays silent. An optional pause, given in microseconds, keeps the coil shorted between consecutive frames. During this pause, field edges are not used.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: A short unit is the 8-sample pattern 1,1,0,0,0,0,0,0. A long unit is the 10-sample pattern 1,1,1,0,0,0,0,0,0,0. Coil level 1 means open and 0 means shorted.
- R2: Group S is six short units (48 samples). Group L is five long units (50 samples). An identifier bit of value 1 is L then S. A bit of value 0 is S then L.
- R3: A frame is built in this order. First comes one short unit. Next is the marker S,S,S,L,L,L,S,L. Then come the 44 identifier bits, most significant first, starting at bit 43. One short unit is inserted before every bit whose index modulo 4 is 3. A frame therefore has 4800 samples.
- R4: The coil level changes only in response to a rising field edge. It then holds until the next one.
- R5: With a pause of zero, frames follow back to back, exactly 4800 field cycles apart. `frame_start` pulses for one clock together with the first sample of every frame, and that sample is 1.
- R6: With a nonzero pause, the coil is shorted for `gap_us` × CLK_PER_US clocks after the last sample's field cycle. Rising edges are ignored during the pause. The frame then restarts from its first sample.
- R7: A start with `id_hi` above 0xFFF is refused. The coil stays open and no frame starts. `id_hi` = 0xFFF is accepted.
- R8: A stop request takes effect at the next rising field edge. The coil then opens and stays open, and no further frames begin.
- R9: After reset the coil is open and `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_clk | input | 1 | Reader field square wave, asynchronous |
| start | input | 1 | Start pulse, taken while idle |
| stop | input | 1 | Stop request |
| id_hi | input | WORD_W | Upper identifier part, must not exceed 0xFFF |
| id_lo | input | WORD_W | Lower 32 identifier bits |
| gap_us | input | GAP_W | Pause between frames in microseconds |
| coil_open | output | 1 | 1 = coil open, 0 = coil shorted |
| frame_start | output | 1 | One-clock pulse with the first sample of each frame |

## Verification
A field rise reaches two synchroniser flops, and the coil register updates on the third clock after the rise. The bench therefore reads each sample one clock after that update. It also reads it again just before the next rise, to confirm the level was held. Frame intervals come from `frame_start` timestamps. With no pause, the interval is exactly 4800 field periods. With a pause, the interval is compared against a window. The lower bound of that window is the pause length, and the upper bound adds the synchroniser latency and up to two field periods of alignment. Refusal and stop are judged over many field periods afterwards, so the latency of one rise does not matter.

// File: rtl/fsk_gen_pkg.sv
package fsk_gen_pkg;

    typedef enum logic [1:0] {PH_LEAD, PH_MARK, PH_SEP, PH_BIT} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} run_e;

    localparam logic [3:0] SHORT_LEN   = 4'd8;
    localparam logic [3:0] SHORT_HIGH  = 4'd2;
    localparam logic [3:0] LONG_LEN    = 4'd10;
    localparam logic [3:0] LONG_HIGH   = 4'd3;
    localparam logic [2:0] SHORT_UNITS = 3'd6;
    localparam logic [2:0] LONG_UNITS  = 3'd5;

    // marker group kinds, index 0 first: S,S,S,L,L,L,S,L (1 = long)
    localparam int         MARK_GROUPS = 8;
    localparam logic [7:0] MARK_KIND   = 8'b1011_1000;

    localparam int SEP_EVERY = 4;
    localparam int SEP_RES   = 3;

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= din;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[g] <= 1'b0;
            else        sh_q[g] <= sh_q[g-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/fsk_gap_timer.sv
module fsk_gap_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_gen_pkg::*;
#(
    parameter int ID_BITS = 44
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [ID_BITS-1:0] id,
    output logic               sample,
    output logic               at_first,
    output logic               at_last
);
    localparam int BIT_W = $clog2(ID_BITS);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(ID_BITS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [2:0]       grp;
        logic [BIT_W-1:0] bit_idx;
        logic             half;
        logic [2:0]       unit;
        logic [3:0]       pos;
    } seq_t;

    localparam seq_t SEQ_INIT = '{phase: PH_LEAD, grp: '0, bit_idx: TOP_BIT,
                                  half: 1'b0, unit: '0, pos: '0};

    seq_t       d, q;
    logic       is_long, lone, end_unit, end_grp;
    logic [3:0] ulen, uhigh;
    logic [2:0] nunits;
    logic [BIT_W-1:0] nxt_bit;

    function automatic logic sep_before(input logic [BIT_W-1:0] b);
        return ((32'(b) % SEP_EVERY) == SEP_RES);
    endfunction

    always_comb begin
        unique case (q.phase)
            PH_MARK: is_long = MARK_KIND[q.grp];
            PH_BIT:  is_long = id[q.bit_idx] ^ q.half;
            default: is_long = 1'b0;
        endcase
        lone     = (q.phase == PH_LEAD) || (q.phase == PH_SEP);
        ulen     = is_long ? LONG_LEN  : SHORT_LEN;
        uhigh    = is_long ? LONG_HIGH : SHORT_HIGH;
        nunits   = lone ? 3'd1 : (is_long ? LONG_UNITS : SHORT_UNITS);
        end_unit = (q.pos == ulen - 4'd1);
        end_grp  = end_unit && (q.unit == nunits - 3'd1);
        sample   = (q.pos < uhigh);
        at_first = (q.phase == PH_LEAD) && (q.pos == '0);
        at_last  = (q.phase == PH_BIT) && (q.bit_idx == '0) && q.half && end_grp;
        nxt_bit  = q.bit_idx - 1'b1;

        d = q;
        if (clear) begin
            d = SEQ_INIT;
        end else if (step) begin
            d.pos = end_unit ? '0 : q.pos + 4'd1;
            if (end_unit) d.unit = end_grp ? '0 : q.unit + 3'd1;
            if (end_grp) begin
                unique case (q.phase)
                    PH_LEAD: begin
                        d.phase = PH_MARK;
                        d.grp   = '0;
                    end
                    PH_MARK: begin
                        if (q.grp == 3'(MARK_GROUPS - 1)) begin
                            d.bit_idx = TOP_BIT;
                            d.half    = 1'b0;
                            d.phase   = sep_before(TOP_BIT) ? PH_SEP : PH_BIT;
                        end else begin
                            d.grp = q.grp + 3'd1;
                        end
                    end
                    PH_SEP: begin
                        d.phase = PH_BIT;
                        d.half  = 1'b0;
                    end
                    default: begin
                        if (!q.half) begin
                            d.half = 1'b1;
                        end else if (q.bit_idx == '0) begin
                            d = SEQ_INIT;
                        end else begin
                            d.bit_idx = nxt_bit;
                            d.half    = 1'b0;
                            d.phase   = sep_before(nxt_bit) ? PH_SEP : PH_BIT;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_INIT;
        else        q <= d;
    end

    p_pos_in_unit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos < ulen);
    p_unit_in_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.unit < nunits);
    p_bit_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.bit_idx <= TOP_BIT);
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
    import fsk_gen_pkg::*;
#(
    parameter int ID_BITS     = 44,
    parameter int HI_BITS     = 12,
    parameter int WORD_W      = 32,
    parameter int GAP_W       = 16,
    parameter int CLK_PER_US  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_clk,
    input  logic              start,
    input  logic              stop,
    input  logic [WORD_W-1:0] id_hi,
    input  logic [WORD_W-1:0] id_lo,
    input  logic [GAP_W-1:0]  gap_us,
    output logic              coil_open,
    output logic              frame_start
);
    localparam int LO_BITS   = ID_BITS - HI_BITS;
    localparam int GAP_CYC_W = GAP_W + $clog2(CLK_PER_US + 1);

    typedef struct packed {
        run_e               run;
        logic               coil;
        logic               fs;
        logic               wrap;
        logic               stop_pend;
        logic [ID_BITS-1:0] id;
    } top_t;

    localparam top_t TOP_INIT = '{run: ST_IDLE, coil: 1'b1, fs: 1'b0,
                                  wrap: 1'b0, stop_pend: 1'b0, id: '0};

    top_t d, q;
    logic fld_rise, fld_fall;
    logic seq_clear, seq_step, seq_sample, seq_first, seq_last;
    logic gap_load, gap_done, id_reject, stop_now;
    logic [GAP_CYC_W-1:0] gap_cycles;

    fsk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(field_clk),
        .rise(fld_rise), .fall(fld_fall)
    );

    fsk_frame_seq #(.ID_BITS(ID_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(seq_clear), .step(seq_step),
        .id(q.id), .sample(seq_sample), .at_first(seq_first), .at_last(seq_last)
    );

    fsk_gap_timer #(.CNT_W(GAP_CYC_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(gap_cycles), .done(gap_done)
    );

    assign id_reject  = |id_hi[WORD_W-1:HI_BITS];
    assign gap_cycles = GAP_CYC_W'(gap_us) * GAP_CYC_W'(CLK_PER_US);
    assign stop_now   = stop || q.stop_pend;

    always_comb begin
        d         = q;
        d.fs      = 1'b0;
        seq_clear = 1'b0;
        seq_step  = 1'b0;
        gap_load  = 1'b0;
        unique case (q.run)
            ST_IDLE: begin
                d.coil = 1'b1;
                if (start && !id_reject) begin
                    d.run       = ST_RUN;
                    d.id        = {id_hi[HI_BITS-1:0], id_lo[LO_BITS-1:0]};
                    d.wrap      = 1'b0;
                    d.stop_pend = 1'b0;
                    seq_clear   = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop) d.stop_pend = 1'b1;
                if (fld_rise) begin
                    if (stop_now) begin
                        d.run  = ST_IDLE;
                        d.coil = 1'b1;
                    end else begin
                        d.coil   = seq_sample;
                        d.fs     = seq_first;
                        d.wrap   = seq_last;
                        seq_step = 1'b1;
                    end
                end else if (fld_fall && q.wrap) begin
                    d.wrap = 1'b0;
                    if (gap_us != '0) begin
                        d.run    = ST_GAP;
                        d.coil   = 1'b0;
                        gap_load = 1'b1;
                    end
                end
            end
            default: begin
                if (stop) d.stop_pend = 1'b1;
                if (fld_rise && stop_now) begin
                    d.run  = ST_IDLE;
                    d.coil = 1'b1;
                end else if (gap_done) begin
                    d.run = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TOP_INIT;
        else        q <= d;
    end

    assign coil_open   = q.coil;
    assign frame_start = q.fs;

    p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run == ST_RUN && !fld_rise && !fld_fall) |=> $stable(coil_open));
    p_first_sample_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> coil_open);
    p_gap_shorted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run == ST_GAP) |-> !coil_open);
    p_reject_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run == ST_IDLE && start && id_reject) |=> (q.run == ST_IDLE));
    p_idle_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run == ST_IDLE) |-> (coil_open && !frame_start));
endmodule

// File: tb/fsk_tag_wavegen_bench.sv
module fsk_tag_wavegen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 4800;
    localparam int FIELD_CLKS = 4;
    localparam int CAP_DEPTH  = 5000;
    localparam int WATCHDOG   = 190000;
    localparam int GAP_US     = 3;
    localparam int CPU        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_clk = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [31:0] id_hi = '0;
    logic [31:0] id_lo = '0;
    logic [15:0] gap_us = '0;
    logic        coil_open, frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int fs_n     = 0;
    int last_fs  = 0;
    int prev_fs  = 0;
    int idx      = CAP_DEPTH;
    int hold_err = 0;
    int tail_n_prev  = 0;
    logic tail_or      = 1'b0;
    logic tail_or_prev = 1'b0;
    logic have_prev    = 1'b0;
    logic prev_coil    = 1'b1;
    logic cap [CAP_DEPTH];
    logic expv [FRAME_LEN];
    int   exp_n;

    fsk_tag_wavegen #(.CLK_PER_US(CPU)) u_fsk_tag_wavegen (
        .clk(clk), .rst_n(rst_n), .field_clk(field_clk), .start(start),
        .stop(stop), .id_hi(id_hi), .id_lo(id_lo), .gap_us(gap_us),
        .coil_open(coil_open), .frame_start(frame_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (frame_start) begin
            prev_fs = last_fs;
            last_fs = cyc;
            fs_n++;
        end
    end

    // field generator and sampler: sample one clock after the coil update
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (have_prev && coil_open !== prev_coil) hold_err++;
            field_clk = 1'b1;
            @(negedge clk);
            @(negedge clk) field_clk = 1'b0;
            @(negedge clk);
            if (frame_start) begin
                tail_n_prev  = (idx > FRAME_LEN) ? idx - FRAME_LEN : 0;
                tail_or_prev = tail_or;
                tail_or      = 1'b0;
                idx          = 0;
            end
            if (idx < CAP_DEPTH) cap[idx] = coil_open;
            if (idx >= FRAME_LEN && idx < CAP_DEPTH) tail_or = tail_or | coil_open;
            if (idx < CAP_DEPTH) idx++;
            prev_coil = coil_open;
            have_prev = 1'b1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expd);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
        end
    endtask

    task automatic add_unit(input int len, input int high);
        for (int i = 0; i < len; i++) begin
            expv[exp_n] = (i < high);
            exp_n++;
        end
    endtask

    task automatic add_group(input logic long_kind);
        if (long_kind) for (int u = 0; u < 5; u++) add_unit(10, 3);
        else           for (int u = 0; u < 6; u++) add_unit(8, 2);
    endtask

    task automatic build_frame(input logic [11:0] hi, input logic [31:0] lo);
        logic [43:0] id;
        logic [7:0]  mark;
        id   = {hi, lo};
        mark = 8'b1011_1000;
        exp_n = 0;
        add_unit(8, 2);
        for (int g = 0; g < 8; g++) add_group(mark[g]);
        for (int b = 43; b >= 0; b--) begin
            if (b % 4 == 3) add_unit(8, 2);
            add_group(id[b]);
            add_group(!id[b]);
        end
    endtask

    task automatic cmp_range(input int from, input int to, input string req);
        int bad, first;
        bad = 0; first = -1;
        for (int i = from; i < to; i++)
            if (cap[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, (first < 0) ? 0 : int'(cap[first]),
            (first < 0) ? 0 : int'(expv[first]));
        if (bad != 0) $display("  first mismatch at sample %0d, %0d bad", first, bad);
    endtask

    task automatic wait_frame(input int target);
        wait (fs_n >= target);
        wait (idx >= FRAME_LEN);
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic do_stop;
        @(negedge clk) stop = 1'b1;
        repeat (FIELD_CLKS * 2) @(negedge clk);
        stop = 1'b0;
        repeat (FIELD_CLKS * 3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        int fs0, base;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(coil_open === 1'b1, "R9 coil open in reset", int'(coil_open), 1);
        chk(frame_start === 1'b0, "R9 frame_start low in reset", int'(frame_start), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R7 refusal of an over-wide upper word
        id_hi = 32'h0000_1000; id_lo = 32'h5555_AAAA;
        fs0 = fs_n;
        pulse_start;
        have_prev = 1'b1;
        base = 1;
        repeat (FIELD_CLKS * 40) begin
            @(negedge clk);
            if (coil_open !== 1'b1) base = 0;
        end
        chk(base == 1, "R7 coil open after refused start", base, 1);
        chk(fs_n == fs0, "R7 no frame after refused start", fs_n, fs0);

        // directed ID, no pause
        id_hi = 32'h0000_0ABC; id_lo = 32'h1234_5678; gap_us = '0;
        build_frame(12'hABC, 32'h1234_5678);
        chk(exp_n == FRAME_LEN, "R3 frame length model", exp_n, FRAME_LEN);
        fs0 = fs_n;
        pulse_start;
        wait_frame(fs0 + 1);
        cmp_range(0, 8, "R1 lead unit 11000000");
        cmp_range(8, 400, "R2 marker groups");
        cmp_range(400, FRAME_LEN, "R3 identifier bits");
        wait_frame(fs0 + 2);
        chk(last_fs - prev_fs == FRAME_LEN * FIELD_CLKS, "R5 back-to-back interval",
            last_fs - prev_fs, FRAME_LEN * FIELD_CLKS);
        chk(tail_n_prev == 0, "R5 no samples between frames", tail_n_prev, 0);
        cmp_range(0, FRAME_LEN, "R5 repeated frame identical");
        chk(hold_err == 0, "R4 level held between field edges", hold_err, 0);

        // R8 stop in mid-frame
        repeat (FIELD_CLKS * 100) @(negedge clk);
        do_stop;
        fs0 = fs_n;
        base = 1;
        repeat (FIELD_CLKS * 60) begin
            @(negedge clk);
            if (coil_open !== 1'b1) base = 0;
        end
        chk(base == 1, "R8 coil open after stop", base, 1);
        chk(fs_n == fs0, "R8 no frame after stop", fs_n, fs0);

        // random ID with a pause
        id_hi = 32'($urandom & 32'hFFF); id_lo = $urandom;
        gap_us = 16'(GAP_US);
        build_frame(id_hi[11:0], id_lo);
        fs0 = fs_n;
        pulse_start;
        wait_frame(fs0 + 1);
        cmp_range(0, FRAME_LEN, "R3 random identifier frame");
        wait_frame(fs0 + 2);
        base = FRAME_LEN * FIELD_CLKS + GAP_US * CPU;
        chk((last_fs - prev_fs >= base) && (last_fs - prev_fs <= base + 3 * FIELD_CLKS),
            "R6 pause lengthens interval", last_fs - prev_fs, base);
        chk(tail_n_prev >= 2 && tail_or_prev == 1'b0, "R6 coil shorted in pause",
            int'(tail_or_prev), 0);
        cmp_range(0, FRAME_LEN, "R6 frame restarts after pause");
        chk(hold_err == 0, "R4 level held through pause", hold_err, 0);
        do_stop;

        // R7 boundary: 0xFFF accepted, all-ones identifier
        id_hi = 32'h0000_0FFF; id_lo = 32'hFFFF_FFFF; gap_us = '0;
        build_frame(12'hFFF, 32'hFFFF_FFFF);
        fs0 = fs_n;
        pulse_start;
        wait_frame(fs0 + 1);
        chk(fs_n > fs0, "R7 upper word 0xFFF accepted", fs_n, fs0 + 1);
        cmp_range(0, FRAME_LEN, "R2 all-ones identifier frame");
        do_stop;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule